// File: doc/BRIEF.md
# Dual-Path Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines and a matching set of software-forced requests into one raw pending vector. Two request outputs are derived from that vector: a normal request and a fast request. Each has its own enable mask, so a source can be routed to either output, to both, or to neither. A build-time mask names the source lines that exist; the bits of absent sources are held at zero everywhere.

Software works through a small synchronous register bus. A write takes effect on the rising clock edge while the write enable is high. Read data is a combinational function of the address and the current state. The enable masks and the software-request latch never need a read-modify-write, because each has a write-one-to-set offset and a write-one-to-clear offset. A handler reads the masked status, services the lowest set bit, and polls again until the status reads zero. Because sources are levels, a bit stays pending until the device behind it drops its line.

Top module: `dual_intc`

## Requirements
- R1: After reset both enable masks and the software-request latch are zero, both request outputs are low, and raw status reads zero while all source inputs are low.
- R2: Raw status reads the same at byte offset 0x04 and at 0x24. Its value is (synchronized source inputs OR software-request latch) AND the valid mask. A change on a source input first shows in raw status two rising edges after it is applied.
- R3: A raw status bit whose valid-mask bit is 0 always reads 0, even when its input is driven high or its software-request bit is written. Under the default mask 0xFFFF00FF these are bits 8 to 15.
- R4: A write to offset 0x08 sets every normal-request enable bit that is 1 in the written word and leaves the other bits unchanged. The normal enable mask reads back at 0x08.
- R5: A write to offset 0x0C clears every normal-request enable bit that is 1 in the written word and leaves the other bits unchanged.
- R6: A write to offset 0x10 sets the software-request bits named by 1s, and a write to 0x14 clears them. A software-request bit shows in raw status from the next cycle on.
- R7: Masked normal status at 0x00 reads raw status AND the normal enable mask. Masked fast status at 0x20 reads raw status AND the fast enable mask. The two masks are independent.
- R8: A write to offset 0x28 sets fast-request enable bits and a write to 0x2C clears them. Neither write changes the normal enable mask. The fast enable mask reads back at 0x28.
- R9: The normal request output equals the OR of masked normal status in the previous cycle. The fast request output equals the OR of masked fast status in the previous cycle.
- R10: A masked status bit and its request output stay asserted for as long as the enabled source line stays high. They fall after the line drops: status two edges later, the output one edge after that.
- R11: Offsets 0x0C, 0x10, 0x14, 0x2C and every unmapped offset read zero. A write to an unmapped offset changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (8) | Byte offset of the register accessed |
| busWe | input | 1 | Write strobe, committed on the rising edge |
| busWdata | input | NUM_SRC (32) | Write data |
| busRdata | output | NUM_SRC (32) | Read data for busAddr, combinational |
| srcIn | input | NUM_SRC (32) | Level-sensitive interrupt source lines, asynchronous |
| irqOut | output | 1 | Normal interrupt request, registered |
| fiqOut | output | 1 | Fast interrupt request, registered |

## Verification
The source lines are driven with a pattern that mixes implemented and absent bits. This shows whether the valid mask is applied, and sampling one edge early shows whether the synchronizer depth is correct. Set and clear words are written with overlapping and disjoint bit groups to tell set-only behaviour apart from overwrite, and a single source is routed to only one output to show that the two masks are independent. A held line, then a dropped one, shows level behaviour and the exact cycle in which each output falls. Software requests, including one aimed at an absent bit, show the OR path into raw status.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Byte offsets of the register window
  localparam logic [7:0] OFF_IRQ_MASKED = 8'h00;
  localparam logic [7:0] OFF_RAW        = 8'h04;
  localparam logic [7:0] OFF_IRQ_EN_SET = 8'h08;
  localparam logic [7:0] OFF_IRQ_EN_CLR = 8'h0C;
  localparam logic [7:0] OFF_SOFT_SET   = 8'h10;
  localparam logic [7:0] OFF_SOFT_CLR   = 8'h14;
  localparam logic [7:0] OFF_FIQ_MASKED = 8'h20;
  localparam logic [7:0] OFF_RAW_ALT    = 8'h24;
  localparam logic [7:0] OFF_FIQ_EN_SET = 8'h28;
  localparam logic [7:0] OFF_FIQ_EN_CLR = 8'h2C;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_IRQ_MASKED,
    RD_RAW,
    RD_IRQ_EN,
    RD_FIQ_MASKED,
    RD_FIQ_EN
  } rdSel_e;

  typedef struct packed {
    logic   irqEnSet;
    logic   irqEnClr;
    logic   fiqEnSet;
    logic   fiqEnClr;
    logic   softSet;
    logic   softClr;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) pipe[s] <= '0;
        else       pipe[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) pipe[s] <= '0;
        else       pipe[s] <= pipe[s-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/intc_regctl.sv
module intc_regctl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobes_t          strb
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  always_comb begin
    strb          = '0;
    strb.irqEnSet = busWe && hit(busAddr, OFF_IRQ_EN_SET);
    strb.irqEnClr = busWe && hit(busAddr, OFF_IRQ_EN_CLR);
    strb.fiqEnSet = busWe && hit(busAddr, OFF_FIQ_EN_SET);
    strb.fiqEnClr = busWe && hit(busAddr, OFF_FIQ_EN_CLR);
    strb.softSet  = busWe && hit(busAddr, OFF_SOFT_SET);
    strb.softClr  = busWe && hit(busAddr, OFF_SOFT_CLR);

    if (hit(busAddr, OFF_IRQ_MASKED))      strb.rdSel = RD_IRQ_MASKED;
    else if (hit(busAddr, OFF_RAW) || hit(busAddr, OFF_RAW_ALT))
                                           strb.rdSel = RD_RAW;
    else if (hit(busAddr, OFF_IRQ_EN_SET)) strb.rdSel = RD_IRQ_EN;
    else if (hit(busAddr, OFF_FIQ_MASKED)) strb.rdSel = RD_FIQ_MASKED;
    else if (hit(busAddr, OFF_FIQ_EN_SET)) strb.rdSel = RD_FIQ_EN;
    else                                   strb.rdSel = RD_ZERO;
  end

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int                  NUM_SRC    = 32,
  parameter logic [NUM_SRC-1:0]  VALID_MASK = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] srcSync,
  output logic [NUM_SRC-1:0] rdata,
  output logic               irqOut,
  output logic               fiqOut
);

  logic [NUM_SRC-1:0] irqEn, fiqEn, softLat;
  logic [NUM_SRC-1:0] rawStat, irqMasked, fiqMasked;

  // Set first, then clear: a bit named by both ends up clear.
  function automatic logic [NUM_SRC-1:0] setClr(
    input logic [NUM_SRC-1:0] cur,
    input logic               doSet,
    input logic               doClr,
    input logic [NUM_SRC-1:0] word
  );
    logic [NUM_SRC-1:0] setBits, clrBits;
    setBits = doSet ? word : '0;
    clrBits = doClr ? word : '0;
    return (cur | setBits) & ~clrBits;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn   <= '0;
      fiqEn   <= '0;
      softLat <= '0;
      irqOut  <= 1'b0;
      fiqOut  <= 1'b0;
    end else begin
      irqEn   <= setClr(irqEn,   strb.irqEnSet, strb.irqEnClr, wdata);
      fiqEn   <= setClr(fiqEn,   strb.fiqEnSet, strb.fiqEnClr, wdata);
      softLat <= setClr(softLat, strb.softSet,  strb.softClr,  wdata);
      irqOut  <= |irqMasked;
      fiqOut  <= |fiqMasked;
    end
  end

  assign rawStat   = (srcSync | softLat) & VALID_MASK;
  assign irqMasked = rawStat & irqEn;
  assign fiqMasked = rawStat & fiqEn;

  always_comb begin
    unique case (strb.rdSel)
      RD_IRQ_MASKED: rdata = irqMasked;
      RD_RAW:        rdata = rawStat;
      RD_IRQ_EN:     rdata = irqEn;
      RD_FIQ_MASKED: rdata = fiqMasked;
      RD_FIQ_EN:     rdata = fiqEn;
      default:       rdata = '0;
    endcase
  end

endmodule

// File: rtl/dual_intc.sv
module dual_intc
  import intc_pkg::*;
#(
  parameter int                 NUM_SRC     = 32,
  parameter int                 ADDR_W      = 8,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [NUM_SRC-1:0] VALID_MASK  = 32'hFFFF_00FF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [NUM_SRC-1:0] busWdata,
  output logic [NUM_SRC-1:0] busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut,
  output logic               fiqOut
);

  strobes_t           strb;
  logic [NUM_SRC-1:0] srcSync;

  intc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (srcIn),
    .dout (srcSync)
  );

  intc_regctl #(.ADDR_W(ADDR_W)) i_ctl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC), .VALID_MASK(VALID_MASK)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (busWdata),
    .srcSync (srcSync),
    .rdata   (busRdata),
    .irqOut  (irqOut),
    .fiqOut  (fiqOut)
  );

endmodule

// File: rtl/dual_intc_chk.sv
module dual_intc_chk #(
  parameter int                 NUM_SRC    = 32,
  parameter int                 ADDR_W     = 8,
  parameter logic [NUM_SRC-1:0] VALID_MASK = '1
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWe,
  input logic [NUM_SRC-1:0] busWdata,
  input logic [NUM_SRC-1:0] busRdata,
  input logic               irqOut,
  input logic               fiqOut
);

  localparam logic [ADDR_W-1:0] A_IRQ_M  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_IRQ_S  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_IRQ_C  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_SOFT_S = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_SOFT_C = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_FIQ_M  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_FIQ_C  = ADDR_W'(8'h2C);

  assert_raw_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == A_RAW) |-> ((busRdata & ~VALID_MASK) == '0));

  assert_enset_sticks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_IRQ_S) ##1 (!busWe && busAddr == A_IRQ_S)
      |-> ((busRdata & $past(busWdata)) == $past(busWdata)));

  assert_enclr_drops_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_IRQ_C) ##1 (!busWe && busAddr == A_IRQ_S)
      |-> ((busRdata & $past(busWdata)) == '0));

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == A_IRQ_M) |=> (irqOut == $past(|busRdata)));

  assert_fiq_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == A_FIQ_M) |=> (fiqOut == $past(|busRdata)));

  assert_wo_reads_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == A_IRQ_C || busAddr == A_SOFT_S || busAddr == A_SOFT_C ||
     busAddr == A_FIQ_C) |-> (busRdata == '0));

endmodule

bind dual_intc dual_intc_chk #(
  .NUM_SRC    (NUM_SRC),
  .ADDR_W     (ADDR_W),
  .VALID_MASK (VALID_MASK)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .irqOut   (irqOut),
  .fiqOut   (fiqOut)
);

// File: tb/test_dual_intc.sv
`timescale 1ns/1ps
module test_dual_intc;

  localparam int          CLK_NS = 20;
  localparam logic [31:0] VALID  = 32'hFFFF_00FF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] srcIn = '0;
  logic        irqOut, fiqOut;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  dual_intc #(.NUM_SRC(32), .ADDR_W(8), .SYNC_STAGES(2), .VALID_MASK(VALID)) i_dual_intc (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .srcIn(srcIn), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic clearAll();
    busWrite(8'h0C, 32'hFFFF_FFFF);
    busWrite(8'h2C, 32'hFFFF_FFFF);
    busWrite(8'h14, 32'hFFFF_FFFF);
    srcIn = '0;
    tick(3);
  endtask

  task automatic testReset();
    logic [31:0] d;
    busRead(8'h08, d); check("R1", "irq enable after reset", d, 0);
    busRead(8'h28, d); check("R1", "fiq enable after reset", d, 0);
    busRead(8'h04, d); check("R1", "raw after reset", d, 0);
    check("R1", "irqOut after reset", {31'b0, irqOut}, 0);
    check("R1", "fiqOut after reset", {31'b0, fiqOut}, 0);
  endtask

  task automatic testRawSync();
    logic [31:0] d;
    srcIn = 32'h8000_1234;
    tick(1);
    busRead(8'h04, d); check("R2", "raw one edge after drive", d, 0);
    tick(1);
    busRead(8'h04, d); check("R2", "raw two edges after drive", d, 32'h8000_1234 & VALID);
    busRead(8'h24, d); check("R2", "raw alias at 0x24", d, 32'h8000_1234 & VALID);
    check("R3", "absent bits 8..15 clear", d & ~VALID, 0);
    srcIn = '0;
    tick(3);
  endtask

  task automatic testIrqEnables();
    logic [31:0] d;
    busWrite(8'h08, 32'h0000_000F);
    busWrite(8'h08, 32'h00F0_0000);
    busRead(8'h08, d); check("R4", "enable set accumulates", d, 32'h00F0_000F);
    busWrite(8'h0C, 32'h0010_0005);
    busRead(8'h08, d); check("R5", "enable clear selective", d, 32'h00E0_000A);
    busRead(8'h0C, d); check("R11", "clear offset reads zero", d, 0);
    busRead(8'h2C, d); check("R11", "fiq clear offset reads zero", d, 0);
    clearAll();
  endtask

  task automatic testMaskedPaths();
    logic [31:0] d;
    srcIn = 32'h8000_0003;
    tick(3);
    busWrite(8'h08, 32'h0000_0002);
    check("R9", "irqOut not yet high", {31'b0, irqOut}, 0);
    busRead(8'h00, d); check("R7", "masked irq", d, 32'h0000_0002);
    busRead(8'h20, d); check("R7", "masked fiq with no enables", d, 0);
    tick(1);
    check("R9", "irqOut one cycle later", {31'b0, irqOut}, 1);
    check("R9", "fiqOut stays low", {31'b0, fiqOut}, 0);
    busWrite(8'h28, 32'h8000_0000);
    busRead(8'h28, d); check("R8", "fiq enable readback", d, 32'h8000_0000);
    busRead(8'h08, d); check("R8", "irq enable untouched", d, 32'h0000_0002);
    busRead(8'h20, d); check("R7", "masked fiq", d, 32'h8000_0000);
    busRead(8'h00, d); check("R7", "masked irq independent", d, 32'h0000_0002);
    tick(1);
    check("R9", "fiqOut high", {31'b0, fiqOut}, 1);
    busWrite(8'h2C, 32'h8000_0000);
    busRead(8'h28, d); check("R8", "fiq enable cleared", d, 0);
    tick(1);
    check("R9", "fiqOut low after clear", {31'b0, fiqOut}, 0);
    clearAll();
  endtask

  task automatic testSoft();
    logic [31:0] d;
    busWrite(8'h10, 32'h0000_0101);
    busRead(8'h04, d); check("R6", "soft request in raw", d, 32'h0000_0001);
    check("R3", "soft request on absent bit dropped", d & 32'h0000_0100, 0);
    busRead(8'h10, d); check("R11", "soft set reads zero", d, 0);
    busWrite(8'h28, 32'h0000_0001);
    tick(1);
    check("R6", "soft request drives fiqOut", {31'b0, fiqOut}, 1);
    busWrite(8'h14, 32'h0000_0001);
    busRead(8'h04, d); check("R6", "soft request cleared", d, 0);
    busRead(8'h14, d); check("R11", "soft clear reads zero", d, 0);
    clearAll();
  endtask

  task automatic testLevel();
    logic [31:0] d;
    busWrite(8'h08, 32'h8000_0000);
    srcIn = 32'h8000_0000;
    tick(3);
    for (int i = 0; i < 3; i++) begin
      busRead(8'h00, d); check("R10", "held level stays pending", d, 32'h8000_0000);
      check("R10", "irqOut held", {31'b0, irqOut}, 1);
      tick(1);
    end
    srcIn = '0;
    tick(1);
    busRead(8'h00, d); check("R10", "pending one edge after drop", d, 32'h8000_0000);
    tick(1);
    busRead(8'h00, d); check("R10", "status clear two edges after drop", d, 0);
    check("R10", "irqOut still high", {31'b0, irqOut}, 1);
    tick(1);
    check("R10", "irqOut falls", {31'b0, irqOut}, 0);
    clearAll();
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    busWrite(8'h08, 32'h0000_0010);
    busWrite(8'h40, 32'hFFFF_FFFF);
    busWrite(8'h3C, 32'hFFFF_FFFF);
    busWrite(8'h09, 32'hFFFF_FFFF);
    busRead(8'h40, d); check("R11", "unmapped reads zero", d, 0);
    busRead(8'h08, d); check("R11", "unmapped write leaves irq enables", d, 32'h0000_0010);
    busRead(8'h28, d); check("R11", "unmapped write leaves fiq enables", d, 0);
    busRead(8'h04, d); check("R11", "unmapped write leaves soft latch", d, 0);
    clearAll();
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    tick(4);
    rstN = 1'b1;
    tick(1);
    testReset();
    testRawSync();
    testIrqEnables();
    testMaskedPaths();
    testSoft();
    testLevel();
    testUnmapped();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checkCount, failCount);
    $finish;
  end

endmodule